// File: doc/BRIEF.md
# Manchester Line Codec

This block converts between a synchronous host data port and a binary chip line. When transmitting, it drives the host bit clock and picks up one NRZ bit at each rising edge of that clock. In Manchester format it sends each bit as two chips; in NRZ format it sends each bit as one chip. When receiving, it samples a chip stream that is already aligned to its own timing. In Manchester format it groups the chips into pairs, turns each valid pair into an NRZ bit and clocks that bit out to the host. A pair whose two chips are equal breaks the code. When the run of such pairs grows longer than a programmable tolerance, the block sets a violation flag. That flag either shows on a status pin, with decoding going on, or stops the decoder.

All timing comes from a clock-enable divider on the system clock. A 3-bit rate code sets the half-slot length H, and every chip lasts 2H. The transmit state machine has the states TX_OFF, TX_MA0, TX_MA1, TX_MB0, TX_MB1, TX_NLO and TX_NHI:
- Manchester format steps TX_MA0 to TX_MA1 to TX_MB0 to TX_MB1 and back to TX_MA0, one step per half-slot tick.
- NRZ format alternates between TX_NLO and TX_NHI.

The receive state machine has the states RX_OFF, RX_MA0, RX_MA1, RX_MB0, RX_MB1, RX_NA and RX_NB. It cycles through them in the same way as the transmit machine.

For both machines, the following transitions apply, and the top takes precedence over the rest:
- Leaving the machine's own mode forces it to its OFF state.
- Entering the machine's own mode sends it from any state to its first state: the A0 state in Manchester format, or TX_NLO or RX_NA in NRZ format.

Top module: `mcodec_top`

## Requirements
- R1: In Manchester transmit, a data bit d is sent as first chip d and then second chip not-d. A 0 is sent as low then high, and a 1 as high then low. The alternating preamble 0101 therefore gives the chips 01 10 01 10.
- R2: In Manchester transmit, host_clk is low for the first chip of a bit and high for the second. host_din is captured at the edge where host_clk rises, and that bit is sent in the next bit period. The first bit after entering transmit is a 0.
- R3: In NRZ transmit (nrz_sel=1 at entry), each bit is one chip equal to the data. host_clk is low for the first half of the chip and high for the second half, and the capture and latency rules of R2 apply.
- R4: The half-slot length is H = BASE_DIV·2^(7−rate_sel) system clocks, so rate code 7 is the fastest. A Manchester bit lasts 4H and an NRZ bit lasts 2H. The host_clk rising edges are spaced by one bit period.
- R5: In Manchester receive, chips are paired starting from mode entry, and each chip is sampled H after its start. A valid pair updates host_dout to its first chip. host_clk then rises H later and stays high for 2H.
- R6: In NRZ receive, every chip becomes one bit on host_dout and one host_clk pulse.
- R7: An equal pair (00 or 11) clocks no bit and leaves host_dout unchanged. It increments a saturating count of consecutive violations, and any valid pair clears that count. The flag sets when the count exceeds vthresh.
- R8: The flag holds through transmit mode. Only reset or a new entry into receive mode clears it.
- R9: With stat_sel=1, viol_stat shows the flag and decoding continues. With stat_sel=0, viol_stat stays low and no further host_clk pulse is given while the flag is set.
- R10: During and right after reset, chip_out, host_clk, host_dout and viol_stat are all 0.
- R11: chip_out is held low whenever the block is in receive mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xmit | input | 1 | 1 selects transmit mode, 0 selects receive mode |
| nrz_sel | input | 1 | 1 selects the NRZ bypass format, taken at mode entry |
| rate_sel | input | 3 | Rate code; 7 is the fastest |
| vthresh | input | THR_W | Tolerated run of consecutive violations |
| stat_sel | input | 1 | 1 routes the flag to viol_stat; 0 makes the flag stop decoding |
| host_din | input | 1 | NRZ transmit data from the host |
| host_dout | output | 1 | Decoded NRZ receive data |
| host_clk | output | 1 | Bit clock to the host; the host acts on its rising edge |
| chip_out | output | 1 | Transmit chip stream |
| chip_in | input | 1 | Received chip stream, aligned to the block's slots |
| viol_stat | output | 1 | Violation flag on the status output |

## Verification
The assertions take several things about the inputs for granted:
- nrz_sel, rate_sel, vthresh and stat_sel are held steady for as long as the block stays in one mode.
- chip_in changes only at chip boundaries measured from mode entry.
- BASE_DIV is at least 2, so no two half-slot ticks are adjacent.

The stimulus keeps to these assumptions. It sets every control input before toggling xmit, and it changes chip_in only on the negative clock edge just before each 2H boundary. It changes host_din only after a falling edge of host_clk, which gives a full half bit of setup before the next capture.

// File: rtl/mcodec_pkg.sv
package mcodec_pkg;
    localparam int RATE_W    = 3;
    localparam int NUM_RATES = 1 << RATE_W;

    typedef enum logic [1:0] {
        LINK_NONE,
        LINK_RX,
        LINK_TX
    } link_mode_e;

    typedef enum logic [2:0] {
        TX_OFF,
        TX_MA0,
        TX_MA1,
        TX_MB0,
        TX_MB1,
        TX_NLO,
        TX_NHI
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_OFF,
        RX_MA0,
        RX_MA1,
        RX_MB0,
        RX_MB1,
        RX_NA,
        RX_NB
    } rx_state_e;
endpackage

// File: rtl/mcodec_slot_timer.sv
module mcodec_slot_timer
    import mcodec_pkg::*;
#(
    parameter int BASE_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              slot_tick
);
    localparam int MAX_H = BASE_DIV << (NUM_RATES - 1);
    localparam int CW    = $clog2(MAX_H) + 1;

    logic [CW-1:0] lim_tab [NUM_RATES];
    logic [CW-1:0] limit;
    logic [CW-1:0] cnt_q;

    // one half-slot length per rate code, slowest at code 0
    for (genvar g = 0; g < NUM_RATES; g++) begin : g_lim
        assign lim_tab[g] = CW'(BASE_DIV << (NUM_RATES - 1 - g));
    end

    assign limit     = lim_tab[rate_sel];
    assign slot_tick = (cnt_q >= limit - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || slot_tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    if (BASE_DIV > 1) begin : g_gap_chk
        AST_SLOT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            slot_tick |=> !slot_tick); // R4
    end
endmodule

// File: rtl/mcodec_tx_fsm.sv
module mcodec_tx_fsm
    import mcodec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic enter,
    input  logic nrz,
    input  logic slot_tick,
    input  logic data_in,
    output logic chip_out,
    output logic bit_clk
);
    tx_state_e state_q, state_d;
    logic      cur_q;
    logic      nxt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!active) begin
            state_d = TX_OFF;
        end else if (enter) begin
            state_d = nrz ? TX_NLO : TX_MA0;
        end else if (slot_tick) begin
            unique case (state_q)
                TX_OFF:  state_d = TX_OFF;
                TX_MA0:  state_d = TX_MA1;
                TX_MA1:  state_d = TX_MB0;
                TX_MB0:  state_d = TX_MB1;
                TX_MB1:  state_d = TX_MA0;
                TX_NLO:  state_d = TX_NHI;
                TX_NHI:  state_d = TX_NLO;
                default: state_d = TX_OFF;
            endcase
        end
    end

    // capture at the host clock rise, promote at the bit boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= 1'b0;
            nxt_q <= 1'b0;
        end else if (enter) begin
            cur_q <= 1'b0;
            nxt_q <= 1'b0;
        end else if (slot_tick) begin
            if (state_q == TX_MA1 || state_q == TX_NLO) nxt_q <= data_in;
            if (state_q == TX_MB1 || state_q == TX_NHI) cur_q <= nxt_q;
        end
    end

    always_comb begin
        chip_out = 1'b0;
        bit_clk  = 1'b0;
        unique case (state_q)
            TX_OFF: begin
                chip_out = 1'b0;
                bit_clk  = 1'b0;
            end
            TX_MA0, TX_MA1: begin
                chip_out = cur_q;
                bit_clk  = 1'b0;
            end
            TX_MB0, TX_MB1: begin
                chip_out = ~cur_q;
                bit_clk  = 1'b1;
            end
            TX_NLO: begin
                chip_out = cur_q;
                bit_clk  = 1'b0;
            end
            TX_NHI: begin
                chip_out = cur_q;
                bit_clk  = 1'b1;
            end
            default: begin
                chip_out = 1'b0;
                bit_clk  = 1'b0;
            end
        endcase
    end

    AST_MAN_MIDBIT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_MB0 && $past(state_q) == TX_MA1) |-> (chip_out != $past(chip_out))); // R1
    AST_TX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bit_clk) |-> (nxt_q == $past(data_in))); // R2
    AST_TX_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!chip_out && !bit_clk)); // R11
endmodule

// File: rtl/mcodec_rx_fsm.sv
module mcodec_rx_fsm
    import mcodec_pkg::*;
#(
    parameter int THR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             enter,
    input  logic             nrz,
    input  logic             slot_tick,
    input  logic             chip_in,
    input  logic [THR_W-1:0] thresh,
    input  logic             stat_sel,
    output logic             data_out,
    output logic             bit_clk,
    output logic             flag
);
    rx_state_e        state_q, state_d;
    logic             chip_a_q;
    logic             data_q;
    logic             pulse_q;
    logic             flag_q;
    logic [THR_W-1:0] vcnt_q;
    logic [THR_W-1:0] vcnt_inc;
    logic             pair_ok;
    logic             abort;

    assign vcnt_inc = (vcnt_q == '1) ? vcnt_q : vcnt_q + THR_W'(1);
    assign pair_ok  = (chip_a_q != chip_in);
    assign abort    = flag_q && !stat_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!active) begin
            state_d = RX_OFF;
        end else if (enter) begin
            state_d = nrz ? RX_NA : RX_MA0;
        end else if (slot_tick) begin
            unique case (state_q)
                RX_OFF:  state_d = RX_OFF;
                RX_MA0:  state_d = RX_MA1;
                RX_MA1:  state_d = RX_MB0;
                RX_MB0:  state_d = RX_MB1;
                RX_MB1:  state_d = RX_MA0;
                RX_NA:   state_d = RX_NB;
                RX_NB:   state_d = RX_NA;
                default: state_d = RX_OFF;
            endcase
        end
    end

    // chip sampling, pair decision and violation tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chip_a_q <= 1'b0;
            data_q   <= 1'b0;
            pulse_q  <= 1'b0;
            flag_q   <= 1'b0;
            vcnt_q   <= '0;
        end else if (enter) begin
            pulse_q  <= 1'b0;
            flag_q   <= 1'b0;
            vcnt_q   <= '0;
        end else if (active && slot_tick) begin
            if (state_q == RX_MA0) begin
                chip_a_q <= chip_in;
            end
            if (state_q == RX_MB0) begin
                if (pair_ok) begin
                    vcnt_q  <= '0;
                    pulse_q <= !abort;
                    if (!abort) data_q <= chip_a_q;
                end else begin
                    vcnt_q  <= vcnt_inc;
                    pulse_q <= 1'b0;
                    if (vcnt_inc > thresh) flag_q <= 1'b1;
                end
            end
            if (state_q == RX_NA) begin
                data_q  <= chip_in;
                pulse_q <= 1'b1;
            end
        end
    end

    always_comb begin
        bit_clk = 1'b0;
        unique case (state_q)
            RX_MA0, RX_MA1, RX_NA: bit_clk = pulse_q;
            RX_OFF, RX_MB0, RX_MB1, RX_NB: bit_clk = 1'b0;
            default: bit_clk = 1'b0;
        endcase
        data_out = data_q;
        flag     = flag_q;
    end

    AST_VIOL_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !enter && slot_tick && state_q == RX_MB0 && !pair_ok) |=> $stable(data_out)); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !enter) |=> flag); // R8
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !stat_sel && !enter) |=> !$rose(bit_clk)); // R9
endmodule

// File: rtl/mcodec_top.sv
module mcodec_top
    import mcodec_pkg::*;
#(
    parameter int BASE_DIV = 2,
    parameter int THR_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xmit,
    input  logic              nrz_sel,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic [THR_W-1:0]  vthresh,
    input  logic              stat_sel,
    input  logic              host_din,
    output logic              host_dout,
    output logic              host_clk,
    output logic              chip_out,
    input  logic              chip_in,
    output logic              viol_stat
);
    link_mode_e mode_q;
    link_mode_e mode_want;
    logic       enter;
    logic       slot_tick;
    logic       tx_clk;
    logic       rx_clk;
    logic       rx_flag;

    assign mode_want = xmit ? LINK_TX : LINK_RX;
    assign enter     = (mode_want != mode_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= LINK_NONE;
        else        mode_q <= mode_want;
    end

    mcodec_slot_timer #(
        .BASE_DIV (BASE_DIV)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (enter),
        .rate_sel  (rate_sel),
        .slot_tick (slot_tick)
    );

    mcodec_tx_fsm i_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (xmit),
        .enter     (enter && xmit),
        .nrz       (nrz_sel),
        .slot_tick (slot_tick),
        .data_in   (host_din),
        .chip_out  (chip_out),
        .bit_clk   (tx_clk)
    );

    mcodec_rx_fsm #(
        .THR_W (THR_W)
    ) i_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (!xmit),
        .enter     (enter && !xmit),
        .nrz       (nrz_sel),
        .slot_tick (slot_tick),
        .chip_in   (chip_in),
        .thresh    (vthresh),
        .stat_sel  (stat_sel),
        .data_out  (host_dout),
        .bit_clk   (rx_clk),
        .flag      (rx_flag)
    );

    assign host_clk  = xmit ? tx_clk : rx_clk;
    assign viol_stat = rx_flag && stat_sel;

    AST_RX_CHIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == LINK_RX) |-> !chip_out); // R11
endmodule

// File: tb/test_mcodec_top.sv
module test_mcodec_top;
    localparam int BD = 2;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          xmit = 1'b0;
    logic          nrz_sel = 1'b0;
    logic [2:0]    rate_sel = 3'd7;
    logic [TW-1:0] vthresh = '0;
    logic          stat_sel = 1'b1;
    logic          host_din = 1'b0;
    logic          host_dout;
    logic          host_clk;
    logic          chip_out;
    logic          chip_in = 1'b0;
    logic          viol_stat;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    mcodec_top #(.BASE_DIV(BD), .THR_W(TW)) i_mcodec_top (
        .clk(clk), .rst_n(rst_n), .xmit(xmit), .nrz_sel(nrz_sel),
        .rate_sel(rate_sel), .vthresh(vthresh), .stat_sel(stat_sel),
        .host_din(host_din), .host_dout(host_dout), .host_clk(host_clk),
        .chip_out(chip_out), .chip_in(chip_in), .viol_stat(viol_stat)
    );

    // {nrz, rate, data byte, expected chips}
    localparam int NV = 7;
    localparam logic [27:0] VEC [NV] = '{
        {1'b0, 3'd7, 8'h00, 16'h5555},
        {1'b0, 3'd7, 8'hFF, 16'hAAAA},
        {1'b0, 3'd6, 8'h55, 16'h6666},
        {1'b0, 3'd7, 8'hA5, 16'h9966},
        {1'b0, 3'd5, 8'hC3, 16'hA55A},
        {1'b1, 3'd7, 8'hA5, 16'h00A5},
        {1'b1, 3'd6, 8'h3C, 16'h003C}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_tx(input bit nrz, input logic [2:0] rate, input logic [7:0] byt, input logic [15:0] exp);
        int h;
        int nch;
        int falls;
        bit prev;
        logic [17:0] got;
        h = BD << (7 - int'(rate));
        nch = nrz ? 9 : 18;
        falls = 0;
        prev = 1'b0;
        got = '0;
        @(negedge clk);
        xmit = 1'b0; nrz_sel = nrz; rate_sel = rate; host_din = byt[7];
        @(negedge clk);
        xmit = 1'b1;
        for (int c = 0; c < 2 * h * nch; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (c % (2 * h) == h) got = {got[16:0], chip_out};
            if (prev && !host_clk) begin
                falls++;
                if (falls < 8) host_din = byt[7 - falls];
            end
            prev = host_clk;
        end
        if (nrz) begin
            chk(got[8] == 1'b0, "R3 nrz idle bit", 32'(got[8]), 0);
            chk(got[7:0] == byt, "R3 nrz chips", 32'(got[7:0]), 32'(byt));
        end else begin
            chk(got[17:16] == 2'b01, "R2 first bit zero", 32'(got[17:16]), 1);
            chk(got[15:0] == exp, "R1 manchester chips", 32'(got[15:0]), 32'(exp));
        end
    endtask

    task automatic run_rx(input bit nrz, input logic [2:0] rate, input logic [31:0] chips, input int nch,
                          output logic [7:0] bits, output int cnt);
        int h;
        int idx;
        bit prev;
        h = BD << (7 - int'(rate));
        bits = '0;
        cnt = 0;
        prev = 1'b0;
        @(negedge clk);
        xmit = 1'b1; nrz_sel = nrz; rate_sel = rate; chip_in = 1'b0;
        @(negedge clk);
        xmit = 1'b0; chip_in = chips[nch - 1];
        for (int c = 0; c < 2 * h * nch + h; c++) begin
            @(posedge clk);
            @(negedge clk);
            if ((c + 1) % (2 * h) == 0) begin
                idx = (c + 1) / (2 * h);
                chip_in = (idx < nch) ? chips[nch - 1 - idx] : 1'b0;
            end
            if (host_clk && !prev) begin
                bits = {bits[6:0], host_dout};
                cnt++;
            end
            prev = host_clk;
        end
        chk(chip_out == 1'b0, "R11 chip_out low in receive", 32'(chip_out), 0);
    endtask

    task automatic measure(input bit nrz, input logic [2:0] rate, input int exp_per);
        int t0;
        int t1;
        bit prev;
        t0 = -1;
        t1 = -1;
        prev = 1'b0;
        @(negedge clk);
        xmit = 1'b0; nrz_sel = nrz; rate_sel = rate;
        @(negedge clk);
        xmit = 1'b1;
        for (int c = 0; c < 8 * exp_per && t1 < 0; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (host_clk && !prev) begin
                if (t0 < 0) t0 = c;
                else t1 = c;
            end
            prev = host_clk;
        end
        chk((t1 - t0) == exp_per, "R4 bit period", 32'(t1 - t0), 32'(exp_per));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] bits;
        int cnt;
        // reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(chip_out == 1'b0, "R10 chip_out in reset", 32'(chip_out), 0);
        chk(host_clk == 1'b0, "R10 host_clk in reset", 32'(host_clk), 0);
        chk(host_dout == 1'b0, "R10 host_dout in reset", 32'(host_dout), 0);
        chk(viol_stat == 1'b0, "R10 viol_stat in reset", 32'(viol_stat), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(chip_out == 1'b0 && host_clk == 1'b0, "R10 idle after reset",
            32'({chip_out, host_clk}), 0);

        // table walk: encode then decode each vector
        vthresh = 4'd3; stat_sel = 1'b1;
        for (int i = 0; i < NV; i++) begin
            run_tx(VEC[i][27], VEC[i][26:24], VEC[i][23:16], VEC[i][15:0]);
            if (VEC[i][27]) begin
                run_rx(1'b1, VEC[i][26:24], {24'h0, VEC[i][23:16]}, 8, bits, cnt);
                chk(bits == VEC[i][23:16], "R6 nrz decode data", 32'(bits), 32'(VEC[i][23:16]));
                chk(cnt == 8, "R6 nrz bit clock count", 32'(cnt), 8);
            end else begin
                run_rx(1'b0, VEC[i][26:24], {16'h0, VEC[i][15:0]}, 16, bits, cnt);
                chk(bits == VEC[i][23:16], "R5 manchester decode data", 32'(bits), 32'(VEC[i][23:16]));
                chk(cnt == 8, "R5 manchester bit clock count", 32'(cnt), 8);
            end
        end

        // bit period per rate code
        measure(1'b0, 3'd5, 32);
        measure(1'b0, 3'd3, 128);
        measure(1'b1, 3'd0, 512);

        // isolated violations stay under a threshold of 1
        vthresh = 4'd1; stat_sel = 1'b1;
        run_rx(1'b0, 3'd7, 32'b1000011110, 10, bits, cnt);
        chk(cnt == 3, "R7 violations give no clock", 32'(cnt), 3);
        chk(bits[2:0] == 3'b101, "R7 valid bits around violations", 32'(bits[2:0]), 5);
        chk(viol_stat == 1'b0, "R7 isolated violations no flag", 32'(viol_stat), 0);

        // two in a row exceed 1: flag on status, decoding continues
        run_rx(1'b0, 3'd7, 32'h21E06, 18, bits, cnt);
        chk(cnt == 5, "R9 decoding continues with status route", 32'(cnt), 5);
        chk(bits[4:0] == 5'b10101, "R9 bits after flag", 32'(bits[4:0]), 21);
        chk(viol_stat == 1'b1, "R7 flag on exceeding threshold", 32'(viol_stat), 1);

        // sticky through transmit, cleared on receive re-entry
        repeat (20) @(negedge clk);
        chk(viol_stat == 1'b1, "R8 flag sticky", 32'(viol_stat), 1);
        xmit = 1'b1;
        @(negedge clk);
        chk(viol_stat == 1'b1, "R8 flag kept in transmit", 32'(viol_stat), 1);
        xmit = 1'b0;
        @(negedge clk);
        chk(viol_stat == 1'b0, "R8 flag cleared on receive entry", 32'(viol_stat), 0);

        // threshold 0 with abort routing
        vthresh = 4'd0; stat_sel = 1'b0;
        run_rx(1'b0, 3'd7, 32'b1001001001, 10, bits, cnt);
        chk(cnt == 2, "R9 abort stops bit clock", 32'(cnt), 2);
        chk(bits[1:0] == 2'b10, "R9 bits before abort", 32'(bits[1:0]), 2);
        chk(viol_stat == 1'b0, "R9 status gated off", 32'(viol_stat), 0);
        chk(host_dout == 1'b0, "R7 data held after violation", 32'(host_dout), 0);

        // threshold 0 with status routing
        stat_sel = 1'b1;
        run_rx(1'b0, 3'd7, 32'b1001001001, 10, bits, cnt);
        chk(cnt == 4, "R9 status route keeps decoding", 32'(cnt), 4);
        chk(bits[3:0] == 4'b1010, "R9 status route bits", 32'(bits[3:0]), 10);
        chk(viol_stat == 1'b1, "R7 single violation over threshold 0", 32'(viol_stat), 1);

        // reset in the middle of transmit
        @(negedge clk);
        xmit = 1'b1; nrz_sel = 1'b0; rate_sel = 3'd7;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(chip_out == 1'b0 && host_clk == 1'b0 && viol_stat == 1'b0, "R10 reset during transmit",
            32'({chip_out, host_clk, viol_stat}), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule